// File: doc/BRIEF.md
# Addressed Serial DAC-Code Write Receiver

This block is a write-only serial slave that loads an 8-bit current-limit setting for a DAC. A host lowers an active-low select, then clocks a fixed 16-bit frame in on falling edges of a serial clock, most significant bit first. The frame carries a fixed header pattern, one address bit that has to match a static strap pin, and eight data bits. When a matching frame completes on its 16th falling clock edge, the data byte is written to the output code register, and a one-cycle strobe goes with it.

The serial pins are brought into the system clock domain through a small synchronizer chain, and their edges are found there. The system clock therefore has to run several times faster than the serial clock. Once a frame has completed, the block takes no further clocks until select has gone high and then low again. A frame that select cuts short is dropped. A frame with a wrong header or a wrong address leaves the register as it was.

Top module: `spi_dac_loader`

## Requirements
- R1: While reset is asserted, and after it is released, `dac_code` is 0x00 and `dac_update` is low.
- R2: A frame starts on a falling edge of `cs_n`. Each falling edge of `sclk` while `cs_n` is low shifts in one bit of `sdi`, most significant bit first.
- R3: In a 16-bit frame, bit 15 must be 0, bit 14 is the address, bit 13 must be 0, bit 12 must be 1, bits 11:4 carry the code (bit 11 is code bit 7), and bits 3:0 are not used.
- R4: A matching frame writes the code on its 16th falling `sclk` edge. `dac_update` is high for exactly one system clock cycle for each write.
- R5: If frame bit 14 differs from `addr_sel`, the frame causes no strobe and `dac_code` keeps its value.
- R6: If any of bits 15, 13 or 12 differs from 0, 0, 1, the frame causes no strobe and `dac_code` keeps its value.
- R7: While `cs_n` stays low after the 16th edge, further `sclk` edges and `sdi` values have no effect.
- R8: If `cs_n` rises before the 16th edge, the partial frame is discarded. The next frame counts its bits from zero.
- R9: After a completed frame, a new write needs `cs_n` to go high and then fall again.
- R10: Bits 3:0 of the frame may hold any value without changing whether the frame is accepted or what code it writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than `sclk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; data sampled on its falling edge |
| sdi | input | 1 | Serial data in, most significant bit first |
| addr_sel | input | 1 | Static strap compared with frame bit 14 |
| dac_code | output | 8 | Current-limit DAC code register |
| dac_update | output | 1 | One-cycle pulse when `dac_code` is written |

## Verification
The checker tests on every cycle that:
- the strobe never lasts more than one cycle;
- the code register changes only in a strobe cycle;
- the bit counter stays inside the frame;
- a finished frame gives no second strobe.

Address and header matching, dropping of short frames, and ignoring of excess clocks depend on whole serial sequences, so only the bench scenarios can show them. The bench compares the final code and the number of strobes after each frame with values it derives from the frame layout.

// File: rtl/spi_dac_loader.sv
module spi_dac_loader #(
  parameter int FRAME_BITS  = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              addr_sel,
  output logic [DATA_W-1:0] dac_code,
  output logic              dac_update
);
  localparam int CNT_W    = $clog2(FRAME_BITS + 1);
  localparam int HDR_W    = 4;
  localparam int DATA_MSB = FRAME_BITS - HDR_W - 1;

  logic [SYNC_STAGES-1:0] cs_pipe, sck_pipe, sdi_pipe, adr_pipe;
  logic                   cs_d, sck_d;
  logic [FRAME_BITS-1:0]  shreg;
  logic [CNT_W-1:0]       bit_cnt;
  logic                   active, frame_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_pipe  <= '1;
      sck_pipe <= '1;
      sdi_pipe <= '0;
      adr_pipe <= '0;
      cs_d     <= 1'b1;
      sck_d    <= 1'b1;
    end else begin
      cs_pipe  <= {cs_pipe[SYNC_STAGES-2:0], cs_n};
      sck_pipe <= {sck_pipe[SYNC_STAGES-2:0], sclk};
      sdi_pipe <= {sdi_pipe[SYNC_STAGES-2:0], sdi};
      adr_pipe <= {adr_pipe[SYNC_STAGES-2:0], addr_sel};
      cs_d     <= cs_pipe[SYNC_STAGES-1];
      sck_d    <= sck_pipe[SYNC_STAGES-1];
    end
  end

  wire cs_s     = cs_pipe[SYNC_STAGES-1];
  wire cs_fall  = cs_d & ~cs_s;
  wire sck_fall = sck_d & ~sck_pipe[SYNC_STAGES-1] & ~cs_s;
  wire last_bit = (bit_cnt == CNT_W'(FRAME_BITS - 1));

  wire [FRAME_BITS-1:0] nxt_word = {shreg[FRAME_BITS-2:0], sdi_pipe[SYNC_STAGES-1]};
  wire [HDR_W-1:0]      hdr_ref  = {1'b0, adr_pipe[SYNC_STAGES-1], 2'b01};
  wire                  hdr_ok   = (nxt_word[FRAME_BITS-1 -: HDR_W] == hdr_ref);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      bit_cnt    <= '0;
      active     <= 1'b0;
      frame_done <= 1'b0;
      dac_code   <= '0;
      dac_update <= 1'b0;
    end else begin
      dac_update <= 1'b0;
      if (cs_s) begin
        active  <= 1'b0;
      end else if (cs_fall) begin
        active     <= 1'b1;
        frame_done <= 1'b0;
        bit_cnt    <= '0;
      end else if (active && sck_fall) begin
        shreg <= nxt_word;
        if (last_bit) begin
          active     <= 1'b0;
          frame_done <= 1'b1;
          if (hdr_ok) begin
            dac_code   <= nxt_word[DATA_MSB -: DATA_W];
            dac_update <= 1'b1;
          end
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_dac_loader_chk.sv
module spi_dac_loader_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5,
  parameter int FRAME_BITS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] dac_code,
  input logic              dac_update,
  input logic              frame_done,
  input logic [CNT_W-1:0]  bit_cnt
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> (dac_code == '0 && !dac_update));

  assert_single_cycle_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dac_update |=> !dac_update);

  assert_code_moves_with_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code) |-> dac_update);

  assert_strobe_ends_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dac_update |-> frame_done);

  assert_no_late_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && $past(frame_done)) |-> !dac_update);

  assert_count_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt < CNT_W'(FRAME_BITS));
endmodule

bind spi_dac_loader spi_dac_loader_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .FRAME_BITS(FRAME_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dac_code(dac_code), .dac_update(dac_update),
  .frame_done(frame_done), .bit_cnt(bit_cnt)
);

// File: tb/tb_spi_dac_loader.sv
`timescale 1ns/1ps
module tb_spi_dac_loader;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0, addr_sel = 1'b0;
  logic [7:0] dac_code;
  logic       dac_update;
  int checks = 0, failures = 0, pulses = 0;

  always #10 clk = ~clk;

  spi_dac_loader dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
                      .addr_sel(addr_sel), .dac_code(dac_code), .dac_update(dac_update));

  always @(negedge clk) if (rst_n && dac_update) pulses++;

  // {pin, word[15:0], nbits[4:0], expect_update, expect_code[7:0]}
  localparam logic [30:0] VEC [13] = '{
    {1'b0, 16'h1A53, 5'd16, 1'b1, 8'hA5},  // R3 R4 basic write
    {1'b1, 16'h53CF, 5'd16, 1'b1, 8'h3C},  // R3 address 1
    {1'b0, 16'h5770, 5'd16, 1'b0, 8'h3C},  // R5 pin 0 frame 1
    {1'b1, 16'h1110, 5'd16, 1'b0, 8'h3C},  // R5 pin 1 frame 0
    {1'b0, 16'h9990, 5'd16, 1'b0, 8'h3C},  // R6 bit15 set
    {1'b0, 16'h3990, 5'd16, 1'b0, 8'h3C},  // R6 bit13 set
    {1'b0, 16'h0990, 5'd16, 1'b0, 8'h3C},  // R6 bit12 clear
    {1'b0, 16'h1FF0, 5'd15, 1'b0, 8'h3C},  // R8 short frame dropped
    {1'b0, 16'h1000, 5'd16, 1'b1, 8'h00},  // R8 next frame counts from zero
    {1'b0, 16'h1FFA, 5'd16, 1'b1, 8'hFF},  // R10 unused bits nonzero
    {1'b0, 16'h1800, 5'd16, 1'b1, 8'h80},  // R2 msb first
    {1'b0, 16'h1010, 5'd16, 1'b1, 8'h01},  // R2 lsb position
    {1'b0, 16'h1660, 5'd20, 1'b1, 8'h66}   // R7 excess clocks
  };

  task automatic shift_bits(input logic [15:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1;
      sdi  = (i < 16) ? w[15-i] : ~sdi;
      repeat (3) @(posedge clk);
      sclk = 1'b0;
      repeat (3) @(posedge clk);
    end
    sclk = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic cs_low();
    cs_n = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  task automatic cs_high();
    cs_n = 1'b1;
    repeat (6) @(posedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] exp_code, input int exp_p, input int p0);
    @(negedge clk);
    checks++;
    if (dac_code !== exp_code || (pulses - p0) != exp_p) begin
      failures++;
      $display("FAIL %s code=%h exp=%h pulses=%0d exp=%0d", req, dac_code, exp_code, pulses - p0, exp_p);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int p0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (dac_code !== 8'h00 || dac_update !== 1'b0) begin
      failures++;
      $display("FAIL R1 in reset code=%h upd=%b exp=00/0", dac_code, dac_update);
    end
    rst_n = 1'b1;
    repeat (6) @(posedge clk);
    check("R1", 8'h00, 0, pulses);

    foreach (VEC[k]) begin
      logic [30:0] v;
      v = VEC[k];
      addr_sel = v[30];
      repeat (4) @(posedge clk);
      p0 = pulses;
      cs_low();
      shift_bits(v[29:14], int'(v[13:9]));
      cs_high();
      check($sformatf("R2-R10 vec%0d", k), v[7:0], int'(v[8]), p0);
    end

    // R7 R9: second burst without releasing select is ignored
    addr_sel = 1'b0;
    repeat (4) @(posedge clk);
    p0 = pulses;
    cs_low();
    shift_bits(16'h1550, 16);
    shift_bits(16'h1220, 16);
    check("R7", 8'h55, 1, p0);
    cs_high();
    check("R9 release alone", 8'h55, 1, p0);
    p0 = pulses;
    cs_low();
    shift_bits(16'h1220, 16);
    cs_high();
    check("R9", 8'h22, 1, p0);

    // R8: select dropped mid-frame, then a full frame
    p0 = pulses;
    cs_low();
    shift_bits(16'h1FF0, 7);
    cs_high();
    cs_low();
    shift_bits(16'h1C30, 16);
    cs_high();
    check("R8", 8'hC3, 1, p0);

    // R1: reset mid-run clears the code
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    p0 = pulses;
    check("R1 reset", 8'h00, 0, p0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule